// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block performs one arithmetic, logic or single-bit shift operation per clock on two operands and produces a result together with a complete 16-bit status word. The operation runs on a full 16-bit word or on the low 8-bit half of the operands. In byte mode the upper half of the first operand passes through to the result unchanged, so a register file can write the whole word back.

The status word has a fixed bit layout. It carries carry, parity, nibble carry for decimal adjust, zero, sign and overflow. Three control bits (trap, interrupt enable, direction) pass from the incoming word to the outgoing word without change. The remaining bits always hold a fixed pattern. Compare and test operations update the flags but leave the destination alone: they deassert the write strobe and return the first operand as the result.

A parameter selects whether the outputs are registered or combinational.

Top module: `status_alu`

## Requirements
- R1: Flag positions in `flags_out` are: carry bit 0, parity bit 2, nibble carry bit 4, zero bit 6, sign bit 7, overflow bit 11.
- R2: Bits 8, 9 and 10 of `flags_out` equal the same bits of `flags_in`. Bit 1 is always 1, and bits 3, 5 and 12 to 15 are always 0, whatever `flags_in` holds.
- R3: Add (0) and add-with-carry (1) produce a+b (plus the incoming carry for opcode 1). Carry is the carry out of the most significant bit. Overflow is set on signed overflow.
- R4: Subtract (2), subtract-with-borrow (3) and negate (7) produce a-b, a-b-carry and 0-a. Carry is set on a borrow out of the most significant bit. Overflow is set on signed overflow.
- R5: The nibble carry flag is the carry (for addition) or borrow (for subtraction) out of bit 3 for opcodes 0 to 7. It is 0 for opcodes 8 to 11 and 13 to 15.
- R6: Parity is 1 when the low 8 result bits hold an even number of ones. Zero is set when the sized result is all zeros. Sign is the most significant bit of the sized result.
- R7: When `byte_mode` is 1, bit 7 is the most significant bit for all flags and shifts, and `result[15:8]` equals `opnd_a[15:8]`.
- R8: Compare (4) and test (11) set the flags exactly as subtract and AND do. They drive `wr_en` low and `result` equal to `opnd_a`. All other opcodes drive `wr_en` high.
- R9: AND (8), OR (9), XOR (10) and test (11) clear carry and overflow. NOT (12) gives the one's complement and leaves bits 0, 2, 4, 6, 7 and 11 equal to `flags_in`.
- R10: Increment (5) and decrement (6) compute a+1 and a-1 and keep carry equal to the incoming carry.
- R11: Shift left (13) moves the old most significant bit into carry, with overflow = new MSB xor carry. Logical right shift (14) and arithmetic right shift (15) move bit 0 into carry. Opcode 14 fills the MSB with 0 and sets overflow to the old MSB. Opcode 15 keeps the MSB and clears overflow.
- R12: With `REG_OUT`=1, outputs change one clock after the inputs are sampled. During synchronous reset `result` is 0, `flags_out` is 0x0002 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code, values as in R3 to R11 |
| byte_mode | input | 1 | 1 selects an 8-bit operation on the low half |
| opnd_a | input | DATA_W | First operand, also the destination value |
| opnd_b | input | DATA_W | Second operand |
| flags_in | input | 16 | Incoming status word |
| result | output | DATA_W | Operation result |
| flags_out | output | 16 | Updated status word |
| wr_en | output | 1 | High when the result should be written back |

## Verification
The bench builds the block with DATA_W=16 and REG_OUT=1. This covers the registered output stage, its one-cycle latency and its reset values, as well as both the byte and word halves of the carry chain. Random operands are biased toward 0, all-ones, and the values just at and below the sign boundary. This brings signed overflow, borrow out of zero, nibble carries and the zero/parity corners into reach for every opcode in both widths.

// File: rtl/status_alu_pkg.sv
`timescale 1ns/1ps
package status_alu_pkg;

    localparam int FLAG_W  = 16;
    localparam int CF_POS  = 0;
    localparam int PF_POS  = 2;
    localparam int AF_POS  = 4;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int OF_POS  = 11;
    localparam logic [FLAG_W-1:0] CTRL_MASK  = 16'h0700;
    localparam logic [FLAG_W-1:0] FIXED_MASK = 16'hF02A;
    localparam logic [FLAG_W-1:0] FIXED_VAL  = 16'h0002;
    localparam logic [FLAG_W-1:0] STAT_MASK  = 16'h08D5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB = 4'd3,
        OP_CMP  = 4'd4,  OP_INC  = 4'd5,  OP_DEC  = 4'd6,  OP_NEG = 4'd7,
        OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR  = 4'd10, OP_TST = 4'd11,
        OP_NOT  = 4'd12, OP_SHL  = 4'd13, OP_SHR  = 4'd14, OP_SAR = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic af;
        logic of;
    } carry_flags_t;

    function automatic logic even_ones8(input logic [7:0] v);
        return ~^v;
    endfunction

    function automatic logic is_sub_op(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) ||
               (op == OP_DEC) || (op == OP_NEG);
    endfunction

    function automatic logic is_flag_only(input alu_op_e op);
        return (op == OP_CMP) || (op == OP_TST);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              nib_cout,
    output logic              ovf
);
    localparam int HALF = DATA_W / 2;

    logic [HALF:0] lo_sum;
    logic [HALF:0] hi_sum;
    logic          x_msb, y_msb, s_msb;

    // Two half-width adders chained; the byte carry is tapped between them.
    assign lo_sum = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
    assign hi_sum = {1'b0, x[DATA_W-1:HALF]} + {1'b0, y[DATA_W-1:HALF]}
                  + {{HALF{1'b0}}, lo_sum[HALF]};
    assign sum    = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};

    // Carry into bit 4 recovered from the sum bit and the two operand bits.
    assign nib_cout = x[4] ^ y[4] ^ lo_sum[4];

    assign x_msb = byte_mode ? x[HALF-1]   : x[DATA_W-1];
    assign y_msb = byte_mode ? y[HALF-1]   : y[DATA_W-1];
    assign s_msb = byte_mode ? sum[HALF-1] : sum[DATA_W-1];
    assign cout  = byte_mode ? lo_sum[HALF] : hi_sum[HALF];
    assign ovf   = (x_msb == y_msb) && (s_msb != x_msb);

endmodule

// File: rtl/alu_logic_shift.sv
`timescale 1ns/1ps
module alu_logic_shift
    import status_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              sh_cout,
    output logic              sh_ovf
);
    localparam int HALF = DATA_W / 2;

    logic msb, next_msb;

    assign msb      = byte_mode ? a[HALF-1] : a[DATA_W-1];
    assign next_msb = byte_mode ? a[HALF-2] : a[DATA_W-2];

    always_comb begin
        res     = a;
        sh_cout = 1'b0;
        sh_ovf  = 1'b0;
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_NOT:         res = ~a;
            OP_SHL: begin
                res     = {a[DATA_W-2:0], 1'b0};
                sh_cout = msb;
                sh_ovf  = next_msb ^ msb;
            end
            OP_SHR: begin
                res     = {1'b0, a[DATA_W-1:1]};
                if (byte_mode) res[HALF-1] = 1'b0;
                sh_cout = a[0];
                sh_ovf  = msb;
            end
            OP_SAR: begin
                res     = {a[DATA_W-1], a[DATA_W-1:1]};
                if (byte_mode) res[HALF-1] = a[HALF-1];
                sh_cout = a[0];
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu_flag_pack.sv
`timescale 1ns/1ps
module alu_flag_pack
    import status_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] core_res,
    input  carry_flags_t      cflags,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int HALF = DATA_W / 2;

    logic zf, sf, pf, cf_new;

    assign zf = byte_mode ? (core_res[HALF-1:0] == '0) : (core_res == '0);
    assign sf = byte_mode ? core_res[HALF-1] : core_res[DATA_W-1];
    assign pf = even_ones8(core_res[7:0]);

    // Increment and decrement keep the incoming carry.
    assign cf_new = ((op == OP_INC) || (op == OP_DEC)) ? flags_in[CF_POS] : cflags.cf;

    always_comb begin
        // Start from the incoming word with the fixed bits forced.
        flags_out = (flags_in & ~FIXED_MASK) | FIXED_VAL;
        if (op != OP_NOT) begin
            flags_out[CF_POS] = cf_new;
            flags_out[PF_POS] = pf;
            flags_out[AF_POS] = cflags.af;
            flags_out[ZF_POS] = zf;
            flags_out[SF_POS] = sf;
            flags_out[OF_POS] = cflags.of;
        end
    end

endmodule

// File: rtl/status_alu.sv
`timescale 1ns/1ps
module status_alu
    import status_alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_sel,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              wr_en
);
    localparam int HALF = DATA_W / 2;

    alu_op_e           op;
    logic              sub_mode, arith_grp, shift_grp;
    logic [DATA_W-1:0] add_x, add_y_raw, add_y, add_sum;
    logic              add_cin, add_cout, add_nib, add_ovf;
    logic [DATA_W-1:0] ls_res;
    logic              sh_cout, sh_ovf;
    logic [DATA_W-1:0] core_res, merged, nxt_result;
    carry_flags_t      cflags;
    logic [FLAG_W-1:0] nxt_flags;
    logic              nxt_wr;

    assign op        = alu_op_e'(op_sel);
    assign sub_mode  = is_sub_op(op);
    assign arith_grp = ~op_sel[3];
    assign shift_grp = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);

    // Operand steering for the shared adder: subtraction adds the inverse.
    always_comb begin
        add_x     = (op == OP_NEG) ? '0 : opnd_a;
        add_y_raw = opnd_b;
        if ((op == OP_INC) || (op == OP_DEC)) add_y_raw = DATA_W'(1);
        else if (op == OP_NEG)                add_y_raw = opnd_a;
        add_y = sub_mode ? ~add_y_raw : add_y_raw;
        unique case (op)
            OP_ADC:                         add_cin = flags_in[CF_POS];
            OP_SBB:                         add_cin = ~flags_in[CF_POS];
            OP_SUB, OP_CMP, OP_DEC, OP_NEG: add_cin = 1'b1;
            default:                        add_cin = 1'b0;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .byte_mode (byte_mode),
        .x         (add_x),
        .y         (add_y),
        .cin       (add_cin),
        .sum       (add_sum),
        .cout      (add_cout),
        .nib_cout  (add_nib),
        .ovf       (add_ovf)
    );

    alu_logic_shift #(.DATA_W(DATA_W)) u_logic (
        .op        (op),
        .byte_mode (byte_mode),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (ls_res),
        .sh_cout   (sh_cout),
        .sh_ovf    (sh_ovf)
    );

    always_comb begin
        if (arith_grp) begin
            core_res  = add_sum;
            cflags.cf = sub_mode ^ add_cout;
            cflags.af = sub_mode ^ add_nib;
            cflags.of = add_ovf;
        end else if (shift_grp) begin
            core_res  = ls_res;
            cflags.cf = sh_cout;
            cflags.af = 1'b0;
            cflags.of = sh_ovf;
        end else begin
            core_res  = ls_res;
            cflags    = '0;
        end
    end

    alu_flag_pack #(.DATA_W(DATA_W)) u_pack (
        .op        (op),
        .byte_mode (byte_mode),
        .core_res  (core_res),
        .cflags    (cflags),
        .flags_in  (flags_in),
        .flags_out (nxt_flags)
    );

    assign merged     = byte_mode ? {opnd_a[DATA_W-1:HALF], core_res[HALF-1:0]} : core_res;
    assign nxt_wr     = ~is_flag_only(op);
    assign nxt_result = nxt_wr ? merged : opnd_a;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    result    <= '0;
                    flags_out <= FIXED_VAL;
                    wr_en     <= 1'b0;
                end else begin
                    result    <= nxt_result;
                    flags_out <= nxt_flags;
                    wr_en     <= nxt_wr;
                end
            end
        end else begin : g_comb
            assign result    = nxt_result;
            assign flags_out = nxt_flags;
            assign wr_en     = nxt_wr;
        end
    endgenerate

endmodule

// File: rtl/status_alu_chk.sv
`timescale 1ns/1ps
module status_alu_chk
    import status_alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_sel,
    input logic              byte_mode,
    input logic [DATA_W-1:0] opnd_a,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_out,
    input logic              wr_en
);
    localparam int HALF = DATA_W / 2;

    alu_op_e           q_op;
    logic              q_byte;
    logic [DATA_W-1:0] q_a;
    logic [FLAG_W-1:0] q_fin;
    logic              primed;

    // Inputs aligned with the outputs they produced.
    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_op   <= OP_ADD;
                    q_byte <= 1'b0;
                    q_a    <= '0;
                    q_fin  <= '0;
                    primed <= 1'b0;
                end else begin
                    q_op   <= alu_op_e'(op_sel);
                    q_byte <= byte_mode;
                    q_a    <= opnd_a;
                    q_fin  <= flags_in;
                    primed <= 1'b1;
                end
            end
        end else begin : g_now
            assign q_op   = alu_op_e'(op_sel);
            assign q_byte = byte_mode;
            assign q_a    = opnd_a;
            assign q_fin  = flags_in;
            assign primed = 1'b1;
        end
    endgenerate

    logic writes_res;
    assign writes_res = (q_op != OP_CMP) && (q_op != OP_TST) && (q_op != OP_NOT);

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (flags_out & FIXED_MASK) == FIXED_VAL);

    p_ctrl_pass_r2: assert property (@(posedge clk) disable iff (rst)
        primed |-> flags_out[10:8] == q_fin[10:8]);

    p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (primed && (q_op == OP_CMP || q_op == OP_TST)) |-> (!wr_en && result == q_a));

    p_write_r8: assert property (@(posedge clk) disable iff (rst)
        (primed && q_op != OP_CMP && q_op != OP_TST) |-> wr_en);

    p_logic_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (primed && (q_op == OP_AND || q_op == OP_OR || q_op == OP_XOR || q_op == OP_TST))
        |-> (!flags_out[CF_POS] && !flags_out[OF_POS] && !flags_out[AF_POS]));

    p_not_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (primed && q_op == OP_NOT) |-> ((flags_out & STAT_MASK) == (q_fin & STAT_MASK)));

    p_incdec_cf_r10: assert property (@(posedge clk) disable iff (rst)
        (primed && (q_op == OP_INC || q_op == OP_DEC)) |-> flags_out[CF_POS] == q_fin[CF_POS]);

    p_byte_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (primed && q_byte) |-> result[DATA_W-1:HALF] == q_a[DATA_W-1:HALF]);

    p_zero_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (primed && writes_res) |->
        (flags_out[ZF_POS] == (q_byte ? (result[HALF-1:0] == '0) : (result == '0))) &&
        (flags_out[SF_POS] == (q_byte ? result[HALF-1] : result[DATA_W-1])));

    p_parity_r6: assert property (@(posedge clk) disable iff (rst)
        (primed && writes_res) |-> flags_out[PF_POS] == ~^result[7:0]);

endmodule

bind status_alu status_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_status_alu_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .byte_mode (byte_mode),
    .opnd_a    (opnd_a),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/status_alu_bench.sv
`timescale 1ns/1ps
module status_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = 16'h0, opnd_b = 16'h0, flags_in = 16'h0;
    logic [15:0] result, flags_out;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    status_alu #(.DATA_W(16), .REG_OUT(1'b1)) u_status_alu (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .byte_mode (byte_mode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    // Expected {wr_en, result, flags} computed from the requirements.
    function automatic logic [32:0] model(input logic [3:0] op, input logic bm,
                                          input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] fin);
        int msk, sb, am, bv, r, x, s, ci, full;
        logic c, af, of, zf, sf, pf, wr;
        logic [15:0] rr, res, fl;
        msk = bm ? 32'h00FF : 32'hFFFF;
        sb  = bm ? 32'h0080 : 32'h8000;
        am  = int'(a) & msk;
        bv  = int'(b) & msk;
        c = fin[0]; af = 1'b0; of = 1'b0; r = 0;
        case (op)
            4'd0, 4'd1, 4'd5: begin
                s    = (op == 4'd5) ? 1 : bv;
                ci   = (op == 4'd1) ? int'(fin[0]) : 0;
                full = am + s + ci;
                r    = full & msk;
                if (op != 4'd5) c = (full > msk);
                af = (((am & 15) + (s & 15) + ci) > 15);
                of = ((am & sb) == (s & sb)) && ((r & sb) != (am & sb));
            end
            4'd2, 4'd3, 4'd4, 4'd6, 4'd7: begin
                x  = (op == 4'd7) ? 0 : am;
                s  = (op == 4'd7) ? am : ((op == 4'd6) ? 1 : bv);
                ci = (op == 4'd3) ? int'(fin[0]) : 0;
                r  = (x - s - ci) & msk;
                if (op != 4'd6) c = (x < s + ci);
                af = ((x & 15) < (s & 15) + ci);
                of = ((x & sb) != (s & sb)) && ((r & sb) != (x & sb));
            end
            4'd8, 4'd11: begin r = am & bv; c = 1'b0; end
            4'd9:        begin r = am | bv; c = 1'b0; end
            4'd10:       begin r = am ^ bv; c = 1'b0; end
            4'd12:       r = (~am) & msk;
            4'd13: begin
                c  = ((am & sb) != 0);
                r  = (am << 1) & msk;
                of = ((r & sb) != 0) ^ c;
            end
            4'd14: begin
                c  = am[0];
                r  = am >> 1;
                of = ((am & sb) != 0);
            end
            default: begin
                c  = am[0];
                r  = (am >> 1) | (am & sb);
            end
        endcase
        rr = r[15:0];
        zf = (rr == 16'h0);
        sf = ((r & sb) != 0);
        pf = ~^rr[7:0];
        fl = (fin & 16'h0700) | 16'h0002;
        if (op == 4'd12) fl = fl | (fin & 16'h08D5);
        else fl = fl | {4'h0, of, 3'b000, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, c};
        wr  = !((op == 4'd4) || (op == 4'd11));
        res = bm ? {a[15:8], rr[7:0]} : rr;
        if (!wr) res = a;
        return {wr, res, fl};
    endfunction

    function automatic string req_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:               return "R3";
            4'd2, 4'd3, 4'd7:         return "R4";
            4'd4, 4'd11:              return "R8";
            4'd5, 4'd6:               return "R10";
            4'd8, 4'd9, 4'd10, 4'd12: return "R9";
            default:                  return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge: drive, wait for the registering edge, compare.
    task automatic run_vec(input logic [3:0] op, input logic bm, input logic [15:0] a,
                           input logic [15:0] b, input logic [15:0] fin, input string extra);
        logic [32:0] e;
        string t;
        e = model(op, bm, a, b, fin);
        op_sel = op; byte_mode = bm; opnd_a = a; opnd_b = b; flags_in = fin;
        @(negedge clk);
        t = $sformatf("%s%s op=%0d bm=%0d a=%h b=%h fin=%h", req_tag(op), extra, op, bm, a, b, fin);
        check({t, " result"}, {16'h0, result}, {16'h0, e[31:16]});
        check({t, " flags R1 R6"}, {16'h0, flags_out}, {16'h0, e[15:0]});
        check({t, " wr_en"}, {31'h0, wr_en}, {31'h0, e[32]});
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom % 8)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h7FFF;
            4: return {8'($urandom), 8'h80};
            5: return {8'($urandom), 8'h7F};
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        opnd_a = 16'hABCD; flags_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R12: reset values
        check("R12 reset result", {16'h0, result}, 32'h0);
        check("R12 reset flags", {16'h0, flags_out}, 32'h0002);
        check("R12 reset wr_en", {31'h0, wr_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: word add wrapping to zero sets carry, parity, nibble carry, zero
        run_vec(4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, " R1 R5");
        check("R1 exact word", {16'h0, flags_out}, 32'h0057);
        // R2: control bits pass, fixed bits forced despite garbage input
        run_vec(4'd8, 1'b0, 16'h0000, 16'h1234, 16'hF72A, " R2");
        check("R2 exact word", {16'h0, flags_out}, 32'h0746);
        // R7: byte add carries out of bit 7, upper half kept
        run_vec(4'd0, 1'b1, 16'h12FF, 16'h3401, 16'h0000, " R7");
        check("R7 byte result", {16'h0, result}, 32'h1200);
        check("R7 byte flags", {16'h0, flags_out}, 32'h0057);
        // R11: byte arithmetic shift right keeps bit 7
        run_vec(4'd15, 1'b1, 16'h5581, 16'h0000, 16'h0000, " R11 R7");
        check("R11 sar byte result", {16'h0, result}, 32'h55C0);
        check("R11 sar byte flags", {16'h0, flags_out}, 32'h0087);
        // R5: borrow out of bit 3 without borrow out of the MSB
        run_vec(4'd2, 1'b0, 16'h0010, 16'h0001, 16'h0000, " R5");
        check("R5 af borrow", {31'h0, flags_out[4]}, 32'h1);
        // R6: parity counts only the low byte
        run_vec(4'd9, 1'b0, 16'h0100, 16'h0003, 16'h0000, " R6");
        check("R6 parity low byte", {31'h0, flags_out[2]}, 32'h1);
        // R4: negate of the most negative value overflows
        run_vec(4'd7, 1'b0, 16'h8000, 16'h0000, 16'h0000, " R4");
        check("R4 neg overflow", {31'h0, flags_out[11]}, 32'h1);
        // R10: increment wrapping keeps incoming carry clear
        run_vec(4'd5, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, " R10");
        check("R10 inc cf", {31'h0, flags_out[0]}, 32'h0);
        // R8 / R9 directed
        run_vec(4'd4, 1'b0, 16'h0005, 16'h0005, 16'h0801, " R8");
        run_vec(4'd12, 1'b1, 16'h00F0, 16'h0000, 16'h08D5, " R9");
        // R3: add with carry chain
        run_vec(4'd1, 1'b0, 16'h7FFF, 16'h0000, 16'h0001, " R3");
        check("R3 adc overflow", {31'h0, flags_out[11]}, 32'h1);

        // R12: output holds until the next edge
        op_sel = 4'd0; byte_mode = 1'b0; opnd_a = 16'h0001; opnd_b = 16'h0001; flags_in = 16'h0;
        @(negedge clk);
        opnd_a = 16'h1000;
        #1;
        check("R12 latency hold", {16'h0, result}, 32'h0002);
        @(negedge clk);
        check("R12 latency update", {16'h0, result}, 32'h1001);

        for (int i = 0; i < 4000; i++) begin
            run_vec(4'($urandom), 1'($urandom), pick16(), pick16(), 16'($urandom), " rnd");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule